// File: doc/BRIEF.md
# Lane-Sliced Double-Data-Rate Hamming Protection

This block adds hidden single-error correction to a small memory whose data path carries two beats per access. The data bus is cut into independent 9-bit lanes (four by default). On a write, each lane pairs its first beat (rising-edge slot) with its second beat (falling-edge slot) into an 18-bit word. It adds 5 Hamming check bits and stores a 23-bit codeword. The check bits never appear at the ports.

On a read, each lane recomputes its syndrome from the stored codeword. It flips the single bit the syndrome points at and returns the repaired word as two 9-bit beats on consecutive cycles. Each lane raises a one-cycle flag when it finds a nonzero syndrome. No multi-bit detection is done and no uncorrectable indication exists.

A fault port XORs one chosen codeword bit of one lane at one address, so that corruption can be created on purpose.

Top module: `ddr_lane_ecc`

## Requirements
- R1: A write is two `wr_valid` cycles: the first carries beat 0 and the second carries beat 1. The codeword is committed at the clock edge that takes beat 1, at the address presented with beat 1. A later read returns beat 0 and then beat 1 unchanged in every lane. Lane l occupies bits [9l+8:9l] of `wr_data` and `rd_beat`.
- R2: After the edge that accepts `rd_req`, `rd_valid` is high for exactly two cycles. In the first of them `rd_beat_idx` is 0 and beat 0 is presented; in the second `rd_beat_idx` is 1 and beat 1 is presented.
- R3: Inverting any single one of the 23 codeword bits of any lane leaves the read data of that lane equal to the written data. Codeword bits are numbered 1 to 23 by `inj_pos`. Check bits sit at positions 1, 2, 4, 8 and 16. Data bits fill the other positions in ascending order, with beat 0 in the low data indices.
- R4: `rd_corrected[l]` is high only during the beat-0 cycle of a read, and only when lane l's syndrome is nonzero. Other lanes' flags and data are unaffected.
- R5: A syndrome that points beyond position 23 flips no bit, but the lane flag is still raised. For example, inverting positions 8 and 16 gives syndrome 24, and the data reads back unchanged with the flag high.
- R6: After reset all stored codewords are zero: a read returns zero data with no flag, and `rd_valid` is low while idle.
- R7: A `rd_req` in the beat-0 cycle is ignored: beat 1 of the current read follows and then `rd_valid` drops. A `rd_req` in any other cycle starts a read.
- R8: A new write to an address replaces a corrupted codeword completely, so the next read returns the new data with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat present |
| wr_addr | input | AW | Write address, taken with beat 1 |
| wr_data | input | LANES*9 | Write beat, 9 bits per lane |
| rd_req | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| rd_valid | output | 1 | Read beat present |
| rd_beat_idx | output | 1 | 0 for beat 0, 1 for beat 1 |
| rd_beat | output | LANES*9 | Corrected read beat |
| rd_corrected | output | LANES | Per-lane nonzero-syndrome flag, beat-0 cycle only |
| inj_en | input | 1 | Invert one stored codeword bit |
| inj_addr | input | AW | Address of the bit to invert |
| inj_lane | input | LW | Lane of the bit to invert |
| inj_pos | input | 5 | Codeword position 1 to 23; other values do nothing |

## Verification
The bench inverts every one of the 23 positions in each lane in turn and expects exact recovery with only that lane flagged. A wrong position map or parity mask would return a data bit inverted, or would raise the flag in the wrong lane. A pair of check-bit faults whose syndrome is 24 guards the range limit: a decoder without it would write to a bit that does not exist, or would fold the position onto a real data bit. Reads held across the beat-0 cycle, and rewrites of a corrupted word, catch an acceptance rule that restarts mid-read and a write path that merges with old contents.

// File: rtl/ddr_ecc_pkg.sv
package ddr_ecc_pkg;
    localparam int BEAT_W = 9;
    localparam int DATA_W = 2 * BEAT_W;
    localparam int CHK_W  = 5;
    localparam int CW_W   = DATA_W + CHK_W;

    typedef enum logic [1:0] {SLOT_IDLE, SLOT_B0, SLOT_B1} slot_e;

    function automatic bit is_chk_pos(int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic logic [CW_W-1:0] ecc_encode(logic [DATA_W-1:0] d);
        logic [CW_W-1:0] cw;
        int j;
        logic par;
        cw = '0;
        j  = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_chk_pos(p)) begin
                cw[p-1] = d[j];
                j++;
            end
        end
        for (int k = 0; k < CHK_W; k++) begin
            par = 1'b0;
            for (int p = 1; p <= CW_W; p++) begin
                if (((p >> k) & 1) == 1 && p != (1 << k)) par ^= cw[p-1];
            end
            cw[(1 << k) - 1] = par;
        end
        return cw;
    endfunction

    function automatic logic [CHK_W-1:0] ecc_syndrome(logic [CW_W-1:0] cw);
        logic [CHK_W-1:0] s;
        s = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (cw[p-1]) s ^= CHK_W'(p);
        end
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] ecc_extract(logic [CW_W-1:0] cw);
        logic [DATA_W-1:0] d;
        int j;
        d = '0;
        j = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_chk_pos(p)) begin
                d[j] = cw[p-1];
                j++;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/ecc_lane_enc.sv
module ecc_lane_enc
    import ddr_ecc_pkg::*;
(
    input  logic [BEAT_W-1:0] beat0,
    input  logic [BEAT_W-1:0] beat1,
    output logic [CW_W-1:0]   cw
);
    always_comb begin
        cw = ecc_encode({beat1, beat0});
    end
endmodule

// File: rtl/ecc_lane_dec.sv
module ecc_lane_dec
    import ddr_ecc_pkg::*;
(
    input  logic [CW_W-1:0]   cw,
    output logic [DATA_W-1:0] data,
    output logic              hit
);
    logic [CHK_W-1:0] syn;
    logic [CW_W-1:0]  fixed;

    always_comb begin
        syn   = ecc_syndrome(cw);
        fixed = cw;
        // Only positions that exist in the codeword are repaired.
        if (syn != '0 && int'(syn) <= CW_W) fixed[int'(syn) - 1] = ~cw[int'(syn) - 1];
        data  = ecc_extract(fixed);
        hit   = (syn != '0);
    end
endmodule

// File: rtl/ecc_cw_store.sv
module ecc_cw_store
    import ddr_ecc_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int ROW_W = LANES * CW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [ROW_W-1:0] wr_row,
    input  logic             inj_en,
    input  logic [AW-1:0]    inj_addr,
    input  logic [LW-1:0]    inj_lane,
    input  logic [4:0]       inj_pos,
    input  logic [AW-1:0]    rd_addr,
    output logic [ROW_W-1:0] rd_row
);
    logic [ROW_W-1:0] mem_d [DEPTH];
    logic [ROW_W-1:0] mem_q [DEPTH];
    int bit_idx;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        bit_idx = int'(inj_lane) * CW_W + int'(inj_pos) - 1;
        if (inj_en && inj_pos != 5'd0 && int'(inj_pos) <= CW_W && int'(inj_lane) < LANES
            && int'(inj_addr) < DEPTH)
            mem_d[inj_addr][bit_idx] = ~mem_q[inj_addr][bit_idx];
        // A committing write overrides a fault on the same row.
        if (wr_en && int'(wr_addr) < DEPTH) mem_d[wr_addr] = wr_row;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_row = (int'(rd_addr) < DEPTH) ? mem_q[rd_addr] : '0;
endmodule

// File: rtl/ddr_lane_ecc.sv
module ddr_lane_ecc
    import ddr_ecc_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int BUS_W = LANES * BEAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [AW-1:0]    wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             rd_req,
    input  logic [AW-1:0]    rd_addr,
    output logic             rd_valid,
    output logic             rd_beat_idx,
    output logic [BUS_W-1:0] rd_beat,
    output logic [LANES-1:0] rd_corrected,
    input  logic             inj_en,
    input  logic [AW-1:0]    inj_addr,
    input  logic [LW-1:0]    inj_lane,
    input  logic [4:0]       inj_pos
);
    typedef struct packed {
        logic                    wr_phase;
        logic [BUS_W-1:0]        hold;
        slot_e                   slot;
        logic [LANES*DATA_W-1:0] word;
        logic [LANES-1:0]        flag;
    } state_t;

    state_t st_d, st_q;
    logic commit;
    logic accept;
    logic [LANES*CW_W-1:0]   enc_row;
    logic [LANES*CW_W-1:0]   rd_row;
    logic [LANES*DATA_W-1:0] dec_word;
    logic [LANES-1:0]        dec_hit;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ecc_lane_enc u_enc (
            .beat0 (st_q.hold[l*BEAT_W +: BEAT_W]),
            .beat1 (wr_data[l*BEAT_W +: BEAT_W]),
            .cw    (enc_row[l*CW_W +: CW_W])
        );
        ecc_lane_dec u_dec (
            .cw   (rd_row[l*CW_W +: CW_W]),
            .data (dec_word[l*DATA_W +: DATA_W]),
            .hit  (dec_hit[l])
        );
    end

    ecc_cw_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit),
        .wr_addr  (wr_addr),
        .wr_row   (enc_row),
        .inj_en   (inj_en),
        .inj_addr (inj_addr),
        .inj_lane (inj_lane),
        .inj_pos  (inj_pos),
        .rd_addr  (rd_addr),
        .rd_row   (rd_row)
    );

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        if (wr_valid) begin
            if (!st_q.wr_phase) begin
                st_d.hold     = wr_data;
                st_d.wr_phase = 1'b1;
            end else begin
                commit        = 1'b1;
                st_d.wr_phase = 1'b0;
            end
        end

        accept = rd_req && (st_q.slot != SLOT_B0);
        if (accept) begin
            st_d.slot = SLOT_B0;
            st_d.word = dec_word;
            st_d.flag = dec_hit;
        end else if (st_q.slot == SLOT_B0) begin
            st_d.slot = SLOT_B1;
            st_d.flag = '0;
        end else begin
            st_d.slot = SLOT_IDLE;
            st_d.flag = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_valid     = (st_q.slot != SLOT_IDLE);
        rd_beat_idx  = (st_q.slot == SLOT_B1);
        rd_corrected = st_q.flag;
        for (int l = 0; l < LANES; l++) begin
            rd_beat[l*BEAT_W +: BEAT_W] = rd_beat_idx
                ? st_q.word[l*DATA_W + BEAT_W +: BEAT_W]
                : st_q.word[l*DATA_W +: BEAT_W];
        end
    end
endmodule

// File: rtl/ddr_lane_ecc_chk.sv
module ddr_lane_ecc_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic             rd_valid,
    input logic             rd_beat_idx,
    input logic [LANES-1:0] rd_corrected
);
    assert_b0_then_b1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_beat_idx |=> rd_valid && rd_beat_idx);

    assert_b1_after_b0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_beat_idx |-> $past(rd_valid) && !$past(rd_beat_idx));

    assert_accept_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !(rd_valid && !rd_beat_idx) |=> rd_valid && !rd_beat_idx);

    assert_flag_in_b0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_corrected) |-> rd_valid && !rd_beat_idx);
endmodule

bind ddr_lane_ecc ddr_lane_ecc_chk #(.LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req       (rd_req),
    .rd_valid     (rd_valid),
    .rd_beat_idx  (rd_beat_idx),
    .rd_corrected (rd_corrected)
);

// File: tb/ddr_lane_ecc_tb.sv
module ddr_lane_ecc_tb;
    localparam int LANES = 4;
    localparam int AW = 4;
    localparam int BW = LANES * 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [BW-1:0] wr_data = '0;
    logic rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic rd_valid, rd_beat_idx;
    logic [BW-1:0] rd_beat;
    logic [LANES-1:0] rd_corrected;
    logic inj_en = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [1:0] inj_lane = '0;
    logic [4:0] inj_pos = '0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ddr_lane_ecc #(.LANES(LANES), .DEPTH(16)) u_dut (.*);

    // {addr, beat1, beat0}
    localparam logic [AW+2*BW-1:0] VEC [8] = '{
        {4'd0,  36'h000000000, 36'hFFFFFFFFF},
        {4'd1,  36'hFFFFFFFFF, 36'h000000000},
        {4'd2,  36'h123456789, 36'hABCDEF012},
        {4'd3,  36'h555555555, 36'hAAAAAAAAA},
        {4'd4,  36'h800000001, 36'h100000008},
        {4'd9,  36'h0FF00FF00, 36'hF00FF00FF},
        {4'd14, 36'h3C3C3C3C3, 36'hC3C3C3C3C},
        {4'd15, 36'h1FF000000, 36'h0000001FF}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [BW-1:0] b0, input logic [BW-1:0] b1);
        @(negedge clk); wr_valid = 1'b1; wr_data = b0; wr_addr = '0;
        @(negedge clk); wr_data = b1; wr_addr = a;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic do_inject(input logic [AW-1:0] a, input int lane, input int pos);
        @(negedge clk); inj_en = 1'b1; inj_addr = a; inj_lane = 2'(lane); inj_pos = 5'(pos);
        @(negedge clk); inj_en = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [BW-1:0] b0, output logic [BW-1:0] b1,
                           output logic [LANES-1:0] f0, output logic [LANES-1:0] f1,
                           output logic [3:0] shape);
        @(negedge clk); rd_req = 1'b1; rd_addr = a;
        @(negedge clk); rd_req = 1'b0;
        b0 = rd_beat; f0 = rd_corrected; shape[1:0] = {rd_valid, rd_beat_idx};
        @(negedge clk);
        b1 = rd_beat; f1 = rd_corrected; shape[3:2] = {rd_valid, rd_beat_idx};
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [BW-1:0] b0, b1;
        logic [LANES-1:0] f0, f1;
        logic [3:0] sh;
        repeat (3) @(negedge clk);
        // R6 reset state
        chk(rd_valid == 1'b0, "R6 idle valid", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;
        do_read(4'd5, b0, b1, f0, f1, sh);
        chk(b0 == '0 && b1 == '0, "R6 zero data", 64'(b0 | b1), 64'd0);
        chk(f0 == '0, "R6 no flag", 64'(f0), 64'd0);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R2 valid drops after beat 1", 64'(rd_valid), 64'd0);

        // R1 / R2 vector walk
        for (int v = 0; v < 8; v++)
            do_write(VEC[v][2*BW +: AW], VEC[v][0 +: BW], VEC[v][BW +: BW]);
        for (int v = 0; v < 8; v++) begin
            do_read(VEC[v][2*BW +: AW], b0, b1, f0, f1, sh);
            chk(b0 == VEC[v][0 +: BW], "R1 beat0", 64'(b0), 64'(VEC[v][0 +: BW]));
            chk(b1 == VEC[v][BW +: BW], "R1 beat1", 64'(b1), 64'(VEC[v][BW +: BW]));
            chk(sh == 4'b1110, "R2 valid/idx", 64'(sh), 64'hE);
            chk(f0 == '0 && f1 == '0, "R4 clean flags", 64'({f1, f0}), 64'd0);
        end

        // R3 / R4 every single-bit fault in every lane
        for (int l = 0; l < LANES; l++) begin
            for (int p = 1; p <= 23; p++) begin
                do_inject(4'd2, l, p);
                do_read(4'd2, b0, b1, f0, f1, sh);
                chk(b0 == VEC[2][0 +: BW] && b1 == VEC[2][BW +: BW], "R3 recovered",
                    64'(b0 ^ b1), 64'(VEC[2][0 +: BW] ^ VEC[2][BW +: BW]));
                chk(f0 == LANES'(1 << l), "R4 lane flag", 64'(f0), 64'(1 << l));
                chk(f1 == '0, "R4 flag one cycle", 64'(f1), 64'd0);
                do_inject(4'd2, l, p);
            end
        end

        // R5 syndrome 24
        do_inject(4'd3, 1, 8);
        do_inject(4'd3, 1, 16);
        do_read(4'd3, b0, b1, f0, f1, sh);
        chk(b0 == VEC[3][0 +: BW] && b1 == VEC[3][BW +: BW], "R5 no flip beyond 23",
            64'(b0), 64'(VEC[3][0 +: BW]));
        chk(f0 == 4'b0010, "R5 flag raised", 64'(f0), 64'h2);
        do_inject(4'd3, 1, 8);
        do_inject(4'd3, 1, 16);

        // R7 request in beat-0 cycle ignored
        @(negedge clk); rd_req = 1'b1; rd_addr = 4'd4;
        @(negedge clk); rd_addr = 4'd9;
        chk(rd_valid && !rd_beat_idx && rd_beat == VEC[4][0 +: BW], "R7 beat0", 64'(rd_beat), 64'(VEC[4][0 +: BW]));
        @(negedge clk); rd_req = 1'b0;
        chk(rd_valid && rd_beat_idx && rd_beat == VEC[4][BW +: BW], "R7 beat1 kept", 64'(rd_beat), 64'(VEC[4][BW +: BW]));
        @(negedge clk);
        chk(rd_valid == 1'b0, "R7 no restart", 64'(rd_valid), 64'd0);

        // R8 rewrite replaces corrupted word
        do_inject(4'd14, 3, 5);
        do_inject(4'd14, 0, 20);
        do_write(4'd14, 36'h0DEADBEEF, 36'h987654321);
        do_read(4'd14, b0, b1, f0, f1, sh);
        chk(b0 == 36'h0DEADBEEF && b1 == 36'h987654321, "R8 new data", 64'(b0), 64'h0DEADBEEF);
        chk(f0 == '0, "R8 no flag", 64'(f0), 64'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule